// File: doc/BRIEF.md
# Load-use hazard stall unit

This block sits beside the decode stage of a five-stage, in-order pipeline. It watches the instruction word held in the fetch/decode register and the instruction word held in the decode/execute register. A load in execute produces its value one stage too late to be forwarded to the instruction right behind it. When that instruction reads the load's destination, the unit freezes the program counter and the fetch/decode register for one cycle. In the same cycle it tells the decode/execute register to take a bubble (the no-operation word) in place of the instruction.

The decision is purely combinational. The consumer's opcode decides which of its register fields count as reads:
- add, nand and beq read both source fields.
- Loads and stores read only the base field.
- halt, noop and jalr read nothing for this purpose.

A taken branch, reported by the memory stage, outranks the stall. In that case the program counter takes the branch target, and both younger pipeline registers are squashed.

Opcodes sit in bits 24:22, with these codes: add 0, nand 1, load 2, store 3, beq 4, jalr 5, halt 6, noop 7. The base field is bits 21:19. The second field is bits 18:16, and it is the destination of a load.

Top module: `load_use_stall`

## Requirements
- R1: When the execute-side opcode (bits 24:22) is not 2 (load), `hazard` is 0 whatever the decode-side word holds.
- R2: With a load in execute and a decode-side opcode of 0, 1 or 4, `hazard` is 1 when the decode word's bits 21:19 equal the load's bits 18:16.
- R3: With a load in execute and a decode-side opcode of 0, 1 or 4, `hazard` is 1 when the decode word's bits 18:16 equal the load's bits 18:16.
- R4: With a load in execute and a decode-side opcode of 2 or 3, `hazard` is 1 only when bits 21:19 match the load's bits 18:16. A match on bits 18:16 alone gives 0.
- R5: A decode-side opcode of 5, 6 or 7 never raises `hazard`.
- R6: With `hazard` at 1 and `redirect` at 0, the outputs are as follows:
  - `hold` is 1.
  - `pc_en` and `fd_en` are 0.
  - `de_squash` is 1.
  - `fd_squash` is 0.
- R7: With `redirect` at 1, the outputs are as follows, whatever `hazard` is:
  - `hold` is 0.
  - `pc_en` and `fd_en` are 1.
  - `fd_squash` and `de_squash` are 1.
- R8: With no hazard and no redirect, `pc_en` and `fd_en` are 1, and `hold`, `fd_squash` and `de_squash` are 0.
- R9: Bits outside the opcode and the two register fields of either word have no effect. This covers the offset, the unused upper bits and the load's base field. The bubble word 0x1C00000 in execute never raises `hazard`, so each hazard stalls exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_word | input | IW | Instruction in the fetch/decode register |
| exe_word | input | IW | Instruction in the decode/execute register |
| redirect | input | 1 | Taken branch resolved this cycle |
| hazard | output | 1 | Load-use dependence detected |
| hold | output | 1 | Effective stall (hazard not overridden) |
| pc_en | output | 1 | Program counter load enable |
| fd_en | output | 1 | Fetch/decode register load enable |
| fd_squash | output | 1 | Force bubble into fetch/decode |
| de_squash | output | 1 | Force bubble into decode/execute |

## Verification
The bench builds the unit with its default field layout: a 32-bit word, a 3-bit opcode at bit 22 and 3-bit register fields at bits 19 and 16. With that layout, every consumer opcode can be placed against a load with matches on the base field, the second field, both fields or neither, including register 0. Filler bits change on every vector, which puts the ignored-bit rule of R9 within reach on each check. Redirect cases are paired with and without a live hazard to show the priority.

// File: rtl/load_use_stall.sv
module load_use_stall #(
  parameter int IW     = 32,
  parameter int OP_LSB = 22,
  parameter int OP_W   = 3,
  parameter int RF_W   = 3,
  parameter int RA_LSB = 19,
  parameter int RB_LSB = 16
) (
  input  logic [IW-1:0] dec_word,
  input  logic [IW-1:0] exe_word,
  input  logic          redirect,
  output logic          hazard,
  output logic          hold,
  output logic          pc_en,
  output logic          fd_en,
  output logic          fd_squash,
  output logic          de_squash
);
  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(0);
  localparam logic [OP_W-1:0] OP_NAND = OP_W'(1);
  localparam logic [OP_W-1:0] OP_LD   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_ST   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_BEQ  = OP_W'(4);

  logic [OP_W-1:0] dec_op, exe_op;
  logic [RF_W-1:0] dec_ra, dec_rb, ld_dst;
  logic            reads_a, reads_b, hit_a, hit_b;

  assign dec_op = dec_word[OP_LSB +: OP_W];
  assign exe_op = exe_word[OP_LSB +: OP_W];
  assign dec_ra = dec_word[RA_LSB +: RF_W];
  assign dec_rb = dec_word[RB_LSB +: RF_W];
  assign ld_dst = exe_word[RB_LSB +: RF_W];

  always_comb begin
    reads_a = 1'b0;
    reads_b = 1'b0;
    case (dec_op)
      OP_ADD, OP_NAND, OP_BEQ: begin reads_a = 1'b1; reads_b = 1'b1; end
      OP_LD, OP_ST:            reads_a = 1'b1;
      default: ;
    endcase
  end

  assign hit_a  = reads_a && (dec_ra == ld_dst);
  assign hit_b  = reads_b && (dec_rb == ld_dst);
  assign hazard = (exe_op == OP_LD) && (hit_a || hit_b);

  assign hold      = hazard && !redirect;
  assign pc_en     = !hold;
  assign fd_en     = !hold;
  assign fd_squash = redirect;
  assign de_squash = hazard || redirect;

  always_comb begin
    if (exe_op != OP_LD)
      p_no_load_no_stall_r1: assert (!hazard);
    if (exe_op == OP_LD && (dec_op == OP_ADD || dec_op == OP_NAND || dec_op == OP_BEQ)
        && (dec_ra == ld_dst || dec_rb == ld_dst))
      p_two_src_match_r2: assert (hazard);
    if (exe_op == OP_LD && (dec_op == OP_LD || dec_op == OP_ST) && dec_ra != ld_dst)
      p_base_only_r4: assert (!hazard);
    if (dec_op > OP_BEQ)
      p_no_reader_r5: assert (!hazard);
    if (hazard && !redirect)
      p_freeze_r6: assert (!pc_en && !fd_en && de_squash && !fd_squash);
    if (redirect)
      p_flush_wins_r7: assert (pc_en && fd_en && fd_squash && de_squash && !hold);
  end
endmodule

// File: tb/load_use_stall_bench.sv
module load_use_stall_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] dec_word, exe_word;
  logic        redirect;
  logic        hazard, hold, pc_en, fd_en, fd_squash, de_squash;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  load_use_stall u_load_use_stall (
    .dec_word(dec_word), .exe_word(exe_word), .redirect(redirect),
    .hazard(hazard), .hold(hold), .pc_en(pc_en), .fd_en(fd_en),
    .fd_squash(fd_squash), .de_squash(de_squash)
  );

  // {redirect, dec_op, dec_a, dec_b, exe_op, exe_dst, expected hazard}
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 3'd0, 3'd1, 3'd2, 3'd2, 3'd1, 1'b1},
    {1'b0, 3'd0, 3'd1, 3'd2, 3'd2, 3'd2, 1'b1},
    {1'b0, 3'd0, 3'd1, 3'd2, 3'd2, 3'd3, 1'b0},
    {1'b0, 3'd1, 3'd5, 3'd6, 3'd2, 3'd6, 1'b1},
    {1'b0, 3'd4, 3'd7, 3'd0, 3'd2, 3'd7, 1'b1},
    {1'b0, 3'd4, 3'd7, 3'd0, 3'd2, 3'd0, 1'b1},
    {1'b0, 3'd2, 3'd3, 3'd4, 3'd2, 3'd3, 1'b1},
    {1'b0, 3'd2, 3'd3, 3'd4, 3'd2, 3'd4, 1'b0},
    {1'b0, 3'd3, 3'd2, 3'd5, 3'd2, 3'd5, 1'b0},
    {1'b0, 3'd3, 3'd2, 3'd5, 3'd2, 3'd2, 1'b1},
    {1'b0, 3'd6, 3'd1, 3'd1, 3'd2, 3'd1, 1'b0},
    {1'b0, 3'd7, 3'd1, 3'd1, 3'd2, 3'd1, 1'b0},
    {1'b0, 3'd5, 3'd1, 3'd1, 3'd2, 3'd1, 1'b0},
    {1'b0, 3'd0, 3'd1, 3'd1, 3'd0, 3'd1, 1'b0},
    {1'b0, 3'd0, 3'd1, 3'd1, 3'd3, 3'd1, 1'b0},
    {1'b0, 3'd0, 3'd1, 3'd1, 3'd7, 3'd1, 1'b0},
    {1'b1, 3'd0, 3'd1, 3'd2, 3'd2, 3'd1, 1'b1},
    {1'b1, 3'd0, 3'd1, 3'd2, 3'd0, 3'd1, 1'b0},
    {1'b0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd0, 1'b1}
  };

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (dec=%h exe=%h redir=%0b)",
               tag, got, exp, dec_word, exe_word, redirect);
    end
  endtask

  task automatic check_ctrl(input logic h, input logic r);
    logic stall;
    stall = h && !r;
    check("R6/R7/R8 hold", hold, stall);
    check("R6/R7/R8 pc_en", pc_en, !stall);
    check("R6/R7/R8 fd_en", fd_en, !stall);
    check("R7 fd_squash", fd_squash, r);
    check("R6/R7 de_squash", de_squash, h || r);
  endtask

  task automatic apply(input logic [31:0] d, input logic [31:0] e, input logic r);
    @(negedge clk);
    dec_word = d; exe_word = e; redirect = r;
    #5;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    dec_word = 32'h01C0_0000; exe_word = 32'h01C0_0000; redirect = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #5;
    check("R8 reset-state hazard", hazard, 1'b0);
    check("R8 reset-state pc_en", pc_en, 1'b1);
    check("R8 reset-state de_squash", de_squash, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      logic [31:0] d, e;
      v = VEC[i];
      d = {7'(i * 13), v[15:13], v[12:10], v[9:7], 16'(i * 4099)};
      e = {7'(i * 29 + 5), v[6:4], ~v[3:1], v[3:1], 16'(i * 777 + 3)};
      apply(d, e, v[16]);
      check("R1/R2/R3/R4/R5 hazard", hazard, v[0]);
      check_ctrl(v[0], v[16]);
    end

    // R3: second-field-only match on add
    apply({7'h00, 3'd0, 3'd4, 3'd6, 16'h0}, {7'h00, 3'd2, 3'd4, 3'd6, 16'h0}, 1'b0);
    check("R3 second field match", hazard, 1'b1);
    // R6: freeze outputs on a base-field hazard for beq
    apply({7'h00, 3'd4, 3'd5, 3'd1, 16'h0}, {7'h00, 3'd2, 3'd0, 3'd5, 16'h0}, 1'b0);
    check("R6 pc_en", pc_en, 1'b0);
    check("R6 de_squash", de_squash, 1'b1);
    // R7: redirect with live hazard
    apply({7'h00, 3'd4, 3'd5, 3'd1, 16'h0}, {7'h00, 3'd2, 3'd0, 3'd5, 16'h0}, 1'b1);
    check("R7 hold overridden", hold, 1'b0);
    check("R7 fd_squash", fd_squash, 1'b1);
    // R9: filler bits set, load base field matching, no real dependence
    apply({7'h7F, 3'd0, 3'd1, 3'd2, 16'hFFFF}, {7'h7F, 3'd2, 3'd1, 3'd3, 16'h0001}, 1'b0);
    check("R9 ignored bits", hazard, 1'b0);
    apply({7'h55, 3'd0, 3'd1, 3'd2, 16'hA5A5}, {7'h2A, 3'd2, 3'd7, 3'd2, 16'h5A5A}, 1'b0);
    check("R9 filler does not mask match", hazard, 1'b1);
    // R9: bubble word in execute never stalls
    for (int r = 0; r < 8; r++) begin
      apply({7'h00, 3'd0, 3'(r), 3'(r), 16'h0}, 32'h01C0_0000, 1'b0);
      check("R9 bubble in execute", hazard, 1'b0);
    end
    // R4 / R5 directed
    apply({7'h00, 3'd3, 3'd6, 3'd6, 16'h0}, {7'h00, 3'd2, 3'd0, 3'd6, 16'h0}, 1'b0);
    check("R4 store base match", hazard, 1'b1);
    apply({7'h00, 3'd6, 3'd6, 3'd6, 16'h0}, {7'h00, 3'd2, 3'd0, 3'd6, 16'h0}, 1'b0);
    check("R5 halt never stalls", hazard, 1'b0);
    // R1 directed: nand producer
    apply({7'h00, 3'd0, 3'd6, 3'd6, 16'h0}, {7'h00, 3'd1, 3'd6, 3'd6, 16'h0006}, 1'b0);
    check("R1 non-load producer", hazard, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule